// File: doc/BRIEF.md
# Deep-Sleep Entry and Wake Sequencer

This always-on block carries the device into deep sleep and back out again. It does this in hardware, after the power-management core has finished its software preparation. Software first sets a one-cycle sleep request. The sequencer then waits until the management core reports that it is idle in wait-for-interrupt. It then stops the high-frequency oscillator and holds the core. After that it switches off the power domains one at a time in index order. Once every domain is off, it sits in the sleep state. There it drives the external power-IC low-power pin, but only if software allowed it before the sequence started.

Wake requests come from an IO chain input and from an internal timer. They are asynchronous to everything, so each one is caught by an edge-set latch and then brought onto the always-on clock through two flops. A wake brings back the oscillator and all domains. The core stays held until the oscillator-good input has been high for a programmable number of consecutive always-on cycles. A wake that arrives while entry is still in progress aborts the entry and takes the same restore path.

A small register interface provides three registers:
- a control bit that allows the external pin;
- the oscillator-stable count;
- a status word with a sticky flag that records a resume from deep sleep.

Top module: `dsleep_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: osc_en is 1, every pd_on bit is 1, pmic_lpm_en is 0 and core_hold is 0. Register reads return 0 at address 0 (control), 4 at address 1 (stable count) and 0 at address 2 (status).
- R2: Entry starts only after a sleep_req pulse is accepted in the active state and core_wfi is then seen high. While the sequencer waits for core_wfi, none of the four sequencing outputs change.
- R3: Entry proceeds in a fixed order. First, osc_en falls and core_hold rises on the same edge. Then exactly one domain switches off per clock, starting at bit 0 and moving upward. The last domain switches off on the edge that enters sleep.
- R4: pmic_lpm_en is 1 only in sleep, and only if control bit 0 was 1 in the cycle the sleep request was accepted. Changing that bit later has no effect on the current sequence.
- R5: A rising edge on wake_io or wake_timer during sleep starts recovery. osc_en and all pd_on bits return to 1, and pmic_lpm_en returns to 0, on the third rising clock edge after the event.
- R6: The core is released only after osc_ok has been high for N consecutive cycles, where N is the stable-count register (a value of 0 acts as 1). A low cycle of osc_ok restarts the count. With osc_ok high throughout, core_hold falls N+1 edges after osc_en rises.
- R7: A wake during entry aborts the sequence. All domains and the oscillator come back, the core is held and then released, and the resume flag stays 0.
- R8: Status is at address 2. Bit 0 is a sticky resume flag that is set when the core is released after sleep was actually reached. Writing 1 to bit 0 clears it, but a set in the same cycle wins over the clear. Bit 1 is 1 while in sleep.
- R9: A wake while active is ignored, and so is a sleep_req after the sequence has left the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Software request to begin deep-sleep entry |
| core_wfi | input | 1 | Management core is idle in wait-for-interrupt |
| wake_io | input | 1 | Asynchronous wake from the IO chain (rising edge) |
| wake_timer | input | 1 | Asynchronous wake from the timer (rising edge) |
| osc_ok | input | 1 | Oscillator reports a usable clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| osc_en | output | 1 | High-frequency oscillator enable |
| pd_on | output | ND (4) | Per-domain power enable |
| pmic_lpm_en | output | 1 | External power-IC low-power enable |
| core_hold | output | 1 | Holds the management core |

## Verification
Two events can land on the same clock edge: the hardware setting the sticky resume flag when the core is released, and a software write-one-to-clear of that flag. The bench waits until core_hold is seen low, which places it in the release cycle. In that cycle it issues the clear write, so the write and the set share one edge. A read back must then show the flag still at 1, and a later clear must show it at 0. All changes on the four sequencing outputs go through an ordered scoreboard. Any change the bench did not predict counts as a failure, so an ignored stimulus is judged by the outputs staying still.

// File: rtl/dsl_pkg.sv
// Shared state encoding and register addresses for the deep-sleep sequencer.
package dsl_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_WAIT_WFI,
        ST_OSC_OFF,
        ST_POWER_OFF,
        ST_SLEEP,
        ST_OSC_ON,
        ST_WAIT_STABLE,
        ST_RELEASE
    } dsl_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STABLE = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/dsl_wake_sync.sv
// Wake capture: each source sets its own latch on a rising edge, with no clock
// involved. The latches go through two flops on the always-on clock. One pulse
// is produced per wake episode. A latch is cleared once its synchronized copy
// has been seen.
// Assumes: a source edge that arrives while its latch is being cleared may be lost.
module dsl_wake_sync #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] wake_src,
    output logic            wake_pulse
);
    logic [NSRC-1:0] lat_vec;
    logic [NSRC-1:0] clr_q;
    logic [NSRC-1:0] s1_q;
    logic [NSRC-1:0] s2_q;
    logic            any3_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic lat;
        // Edge-set latch with a clear from the clock domain.
        always_ff @(posedge wake_src[i] or posedge clr_q[i]) begin
            if (clr_q[i]) lat <= 1'b0;
            else          lat <= 1'b1;
        end
        assign lat_vec[i] = lat;
    end

    // Two-flop synchronizer, clear generation and edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            any3_q <= 1'b0;
            clr_q  <= '1;
        end else begin
            s1_q   <= lat_vec;
            s2_q   <= s1_q;
            any3_q <= |s2_q;
            clr_q  <= s2_q;
        end
    end

    assign wake_pulse = (|s2_q) & ~any3_q;
endmodule

// File: rtl/dsl_regs.sv
// Register file: allow bit for the power-IC pin, the oscillator-stable count and
// the status word (sticky resume flag, cleared by writing 1, set wins; live sleep bit).
// Assumes: one access per cycle, reads are combinational.
module dsl_regs #(
    parameter int DW         = 16,
    parameter int CNT_W      = 8,
    parameter int STABLE_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             set_resumed,
    input  logic             in_sleep,
    output logic             pmic_allow,
    output logic [CNT_W-1:0] stable_n
);
    import dsl_pkg::*;

    logic resumed_q;
    logic w1c;

    assign w1c = reg_we && (reg_addr == ADDR_STATUS) && reg_wdata[0];

    // Writable configuration and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmic_allow <= 1'b0;
            stable_n   <= CNT_W'(STABLE_RST);
            resumed_q  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == ADDR_CTRL)   pmic_allow <= reg_wdata[0];
            if (reg_we && reg_addr == ADDR_STABLE) stable_n   <= reg_wdata[CNT_W-1:0];
            if (set_resumed)  resumed_q <= 1'b1;
            else if (w1c)     resumed_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:   reg_rdata[0] = pmic_allow;
            ADDR_STABLE: reg_rdata[CNT_W-1:0] = stable_n;
            ADDR_STATUS: reg_rdata[1:0] = {in_sleep, resumed_q};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dsl_fsm.sv
// Sequencing state machine. It waits for the core, stops the oscillator, turns
// the domains off one per cycle from bit 0, sleeps, restores on wake and waits
// for the oscillator to be stable. Every output is registered from the next
// state, so each one changes on the same edge as the state that owns it.
// Assumes: wake_pulse is synchronous to clk; ND >= 1.
module dsl_fsm #(
    parameter int ND    = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             core_wfi,
    input  logic             wake_pulse,
    input  logic             osc_ok,
    input  logic             pmic_allow,
    input  logic [CNT_W-1:0] stable_n,
    output logic             osc_en,
    output logic [ND-1:0]    pd_on,
    output logic             pmic_lpm_en,
    output logic             core_hold,
    output logic             in_sleep,
    output logic             set_resumed
);
    import dsl_pkg::*;

    localparam int IW = (ND > 1) ? $clog2(ND) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(ND - 1);

    dsl_state_e     state_q, nxt;
    logic [IW-1:0]  idx_q;
    logic [CNT_W:0] cnt_q;
    logic [CNT_W:0] need;
    logic           allow_snap_q;
    logic           reached_q;

    assign need = (stable_n == '0) ? (CNT_W+1)'(1) : {1'b0, stable_n};

    // Next-state decision; a wake takes priority during entry.
    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_ACTIVE:      if (sleep_req) nxt = ST_WAIT_WFI;
            ST_WAIT_WFI:    if (wake_pulse) nxt = ST_OSC_ON;
                            else if (core_wfi) nxt = ST_OSC_OFF;
            ST_OSC_OFF:     nxt = wake_pulse ? ST_OSC_ON : ST_POWER_OFF;
            ST_POWER_OFF:   if (wake_pulse) nxt = ST_OSC_ON;
                            else if (idx_q == LAST_IDX) nxt = ST_SLEEP;
            ST_SLEEP:       if (wake_pulse) nxt = ST_OSC_ON;
            ST_OSC_ON:      nxt = ST_WAIT_STABLE;
            ST_WAIT_STABLE: if (osc_ok && (cnt_q + 1'b1 >= need)) nxt = ST_RELEASE;
            ST_RELEASE:     nxt = ST_ACTIVE;
            default:        nxt = ST_ACTIVE;
        endcase
    end

    // State, counters, snapshots and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_ACTIVE;
            idx_q        <= '0;
            cnt_q        <= '0;
            allow_snap_q <= 1'b0;
            reached_q    <= 1'b0;
            osc_en       <= 1'b1;
            pd_on        <= '1;
            pmic_lpm_en  <= 1'b0;
            core_hold    <= 1'b0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_ACTIVE && nxt == ST_WAIT_WFI) allow_snap_q <= pmic_allow;
            if (state_q == ST_SLEEP)       reached_q <= 1'b1;
            else if (state_q == ST_ACTIVE) reached_q <= 1'b0;
            if (state_q == ST_POWER_OFF && nxt == ST_POWER_OFF) idx_q <= idx_q + 1'b1;
            else if (state_q != ST_POWER_OFF)                   idx_q <= '0;
            if (state_q == ST_WAIT_STABLE) cnt_q <= osc_ok ? cnt_q + 1'b1 : '0;
            else                           cnt_q <= '0;
            if (nxt == ST_OSC_ON)                                 pd_on        <= '1;
            else if (state_q == ST_POWER_OFF && nxt != ST_OSC_ON) pd_on[idx_q] <= 1'b0;
            osc_en      <= !(nxt inside {ST_OSC_OFF, ST_POWER_OFF, ST_SLEEP});
            core_hold   <= nxt inside {ST_OSC_OFF, ST_POWER_OFF, ST_SLEEP,
                                       ST_OSC_ON, ST_WAIT_STABLE};
            pmic_lpm_en <= (nxt == ST_SLEEP) && allow_snap_q;
        end
    end

    assign in_sleep    = (state_q == ST_SLEEP);
    assign set_resumed = (state_q == ST_RELEASE) && reached_q;
endmodule

// File: rtl/dsleep_ctrl.sv
// Top of the always-on deep-sleep sequencer: wake capture, register file and
// state machine. Assumes clk is the always-on slow clock and never stops.
module dsleep_ctrl #(
    parameter int ND         = 4,
    parameter int CNT_W      = 8,
    parameter int STABLE_RST = 4,
    parameter int DW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic          core_wfi,
    input  logic          wake_io,
    input  logic          wake_timer,
    input  logic          osc_ok,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          osc_en,
    output logic [ND-1:0] pd_on,
    output logic          pmic_lpm_en,
    output logic          core_hold
);
    logic             wake_pulse;
    logic             pmic_allow;
    logic [CNT_W-1:0] stable_n;
    logic             in_sleep;
    logic             set_resumed;

    dsl_wake_sync #(.NSRC(2)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_src   ({wake_timer, wake_io}),
        .wake_pulse (wake_pulse)
    );

    dsl_regs #(.DW(DW), .CNT_W(CNT_W), .STABLE_RST(STABLE_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .set_resumed (set_resumed),
        .in_sleep    (in_sleep),
        .pmic_allow  (pmic_allow),
        .stable_n    (stable_n)
    );

    dsl_fsm #(.ND(ND), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .core_wfi    (core_wfi),
        .wake_pulse  (wake_pulse),
        .osc_ok      (osc_ok),
        .pmic_allow  (pmic_allow),
        .stable_n    (stable_n),
        .osc_en      (osc_en),
        .pd_on       (pd_on),
        .pmic_lpm_en (pmic_lpm_en),
        .core_hold   (core_hold),
        .in_sleep    (in_sleep),
        .set_resumed (set_resumed)
    );
endmodule

// File: rtl/dsl_checker.sv
// Port-level properties of the sequencer, attached to every dsleep_ctrl by bind.
module dsl_checker #(
    parameter int ND = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_wfi,
    input logic          osc_ok,
    input logic          osc_en,
    input logic [ND-1:0] pd_on,
    input logic          pmic_lpm_en,
    input logic          core_hold
);
    assert_pmic_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pmic_lpm_en |-> (!osc_en && pd_on == '0 && core_hold));

    assert_osc_off_holds_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> core_hold);

    assert_domains_off_after_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_on != '1) |-> !osc_en);

    assert_one_domain_per_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pd_on) < $countones($past(pd_on)))
        |-> ($countones($past(pd_on)) == $countones(pd_on) + 1));

    assert_entry_after_wfi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(core_wfi));

    assert_release_when_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> (osc_en && $past(osc_ok)));
endmodule

bind dsleep_ctrl dsl_checker #(.ND(ND)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_wfi    (core_wfi),
    .osc_ok      (osc_ok),
    .osc_en      (osc_en),
    .pd_on       (pd_on),
    .pmic_lpm_en (pmic_lpm_en),
    .core_hold   (core_hold)
);

// File: tb/sim_dsleep_ctrl.sv
// Scoreboard bench: scenario tasks queue the expected sequence of output states,
// and a negedge monitor pops and compares each change it observes.
module sim_dsleep_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;

    typedef struct packed {
        logic          osc;
        logic [ND-1:0] pd;
        logic          pmic;
        logic          hold;
    } obs_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic          core_wfi = 1'b0;
    logic          wake_io = 1'b0;
    logic          wake_timer = 1'b0;
    logic          osc_ok = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [15:0]   reg_wdata = 16'd0;
    logic [15:0]   reg_rdata;
    logic          osc_en;
    logic [ND-1:0] pd_on;
    logic          pmic_lpm_en;
    logic          core_hold;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   t_osc_up = 0;
    int   t_hold_dn = 0;
    int   c_wake = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    obs_t prev;
    obs_t exp_q[$];
    string tag_q[$];

    dsleep_ctrl #(.ND(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .core_wfi(core_wfi),
        .wake_io(wake_io), .wake_timer(wake_timer), .osc_ok(osc_ok),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .osc_en(osc_en), .pd_on(pd_on),
        .pmic_lpm_en(pmic_lpm_en), .core_hold(core_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic obs_t mk(logic o, logic [ND-1:0] p, logic m, logic h);
        obs_t r;
        r.osc = o; r.pd = p; r.pmic = m; r.hold = h;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(obs_t e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [15:0] exp);
        reg_addr = a;
        #1;
        check(req, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake(bit use_timer);
        c_wake = cyc;
        #2;
        if (use_timer) wake_timer = 1'b1; else wake_io = 1'b1;
        #2;
        wake_timer = 1'b0; wake_io = 1'b0;
    endtask

    task automatic drained(string req);
        #1;
        check(req, exp_q.size(), 0);
    endtask

    // Monitor: every change of the output state must match the next expected item.
    always @(negedge clk) begin
        if (mon_en) begin
            obs_t cur, e;
            string tg;
            cur = mk(osc_en, pd_on, pmic_lpm_en, core_hold);
            if (cur !== prev) begin
                if (cur.osc && !prev.osc) t_osc_up = cyc;
                if (!cur.hold && prev.hold) t_hold_dn = cyc;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R9 unexpected change actual=%0h expected=%0h", cur, prev);
                end else begin
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (cur !== e) begin
                        bad++;
                        $display("FAIL %s actual=%0h expected=%0h", tg, cur, e);
                    end
                end
                prev = cur;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", {28'd0, osc_en, pd_on, pmic_lpm_en, core_hold},
              {28'd0, mk(1'b1, '1, 1'b0, 1'b0)});
        rd_check("R1 ctrl", 2'd0, 16'd0);
        rd_check("R1 stable", 2'd1, 16'd4);
        rd_check("R1 status", 2'd2, 16'd0);
        prev = mk(osc_en, pd_on, pmic_lpm_en, core_hold);
        mon_en = 1'b1;

        // R9: a wake while active changes nothing
        @(negedge clk);
        pulse_wake(1'b1);
        cycles(8);
        rd_check("R9 status after idle wake", 2'd2, 16'd0);
        drained("R9 idle wake");

        // Full sleep with the power-IC pin allowed, stable count 4
        @(negedge clk);
        wr(2'd0, 16'd1);
        pulse_sleep();
        cycles(5);
        check("R2 waits for wfi", {31'd0, osc_en}, 32'd1);
        push(mk(1'b0, 4'b1111, 1'b0, 1'b1), "R3 osc off");
        push(mk(1'b0, 4'b1110, 1'b0, 1'b1), "R3 domain 0");
        push(mk(1'b0, 4'b1100, 1'b0, 1'b1), "R3 domain 1");
        push(mk(1'b0, 4'b1000, 1'b0, 1'b1), "R3 domain 2");
        push(mk(1'b0, 4'b0000, 1'b1, 1'b1), "R4 sleep pin on");
        core_wfi = 1'b1;
        cycles(10);
        rd_check("R8 asleep bit", 2'd2, 16'd2);
        pulse_sleep();
        cycles(4);
        rd_check("R9 sleep_req in sleep", 2'd2, 16'd2);
        drained("R3 entry sequence");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b1), "R5 restore");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b0), "R6 release");
        @(negedge clk);
        pulse_wake(1'b0);
        osc_ok = 1'b1;
        while (core_hold) @(negedge clk);
        // Release cycle: the clear collides with the hardware set (R8)
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'd1;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check("R5 wake latency", t_osc_up - c_wake, 3);
        check("R6 stable count 4", t_hold_dn - t_osc_up, 5);
        rd_check("R8 set wins over clear", 2'd2, 16'd1);
        @(negedge clk);
        wr(2'd2, 16'd1);
        rd_check("R8 clear by write one", 2'd2, 16'd0);
        core_wfi = 1'b0;
        osc_ok = 1'b0;
        drained("R6 wake sequence");

        // Pin not allowed at start, allowed mid-sequence; stable count 0
        wr(2'd1, 16'd0);
        wr(2'd0, 16'd0);
        pulse_sleep();
        wr(2'd0, 16'd1);
        push(mk(1'b0, 4'b1111, 1'b0, 1'b1), "R3 osc off");
        push(mk(1'b0, 4'b1110, 1'b0, 1'b1), "R3 domain 0");
        push(mk(1'b0, 4'b1100, 1'b0, 1'b1), "R3 domain 1");
        push(mk(1'b0, 4'b1000, 1'b0, 1'b1), "R3 domain 2");
        push(mk(1'b0, 4'b0000, 1'b0, 1'b1), "R4 pin stays off");
        core_wfi = 1'b1;
        cycles(10);
        drained("R4 snapshot entry");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b1), "R5 restore");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b0), "R6 release");
        pulse_wake(1'b1);
        cycles(10);
        check("R6 held while osc not ok", {31'd0, core_hold}, 32'd1);
        c_wake = cyc;
        osc_ok = 1'b1;
        while (core_hold) @(negedge clk);
        #1;
        check("R6 zero count acts as one", t_hold_dn - c_wake, 1);
        cycles(2);
        rd_check("R8 resume flag set", 2'd2, 16'd1);
        wr(2'd2, 16'd1);
        core_wfi = 1'b0;
        osc_ok = 1'b0;
        drained("R6 second wake");

        // R7: abort while waiting for the core
        pulse_sleep();
        cycles(2);
        push(mk(1'b1, 4'b1111, 1'b0, 1'b1), "R7 abort hold");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b0), "R7 abort release");
        osc_ok = 1'b1;
        pulse_wake(1'b0);
        cycles(10);
        rd_check("R7 no resume flag", 2'd2, 16'd0);
        osc_ok = 1'b0;
        drained("R7 abort in wait");

        // R7: abort after one domain is off
        pulse_sleep();
        cycles(2);
        push(mk(1'b0, 4'b1111, 1'b0, 1'b1), "R7 osc off");
        push(mk(1'b0, 4'b1110, 1'b0, 1'b1), "R7 domain 0");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b1), "R7 restore");
        push(mk(1'b1, 4'b1111, 1'b0, 1'b0), "R7 release");
        core_wfi = 1'b1;
        osc_ok = 1'b1;
        @(negedge clk);
        pulse_wake(1'b1);
        cycles(12);
        rd_check("R7 no resume after abort", 2'd2, 16'd0);
        core_wfi = 1'b0;
        drained("R7 abort in power-off");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule